// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a CPU write port and the sequencer that drives an on-chip flash array. Software issues each flash command as two bus writes. The first write carries a command code in its low data byte. The second write carries either the word to program or a confirm byte. The decoder checks that the two writes form a legal sequence. When they do, it issues a one-cycle start pulse to the external sequencer. The pulse comes with a latched target address, a data word and a block mask.

The sequencer runs the array operation and reports back over a busy/done handshake. While that handshake shows an operation in flight, the decoder refuses new commands. A status input reports that the main clock is stopped. While it is high, every command that modifies the array or reads status is refused. Illegal sequences and clock refusals each raise their own sticky flag, and a single-write clear command lowers both flags.

The user ROM region starts at `ROM_BASE` and holds `NUM_BLK` blocks of `2**BLK_SHIFT` bytes each. The top word of block k is at `ROM_BASE + (k+1)*2**BLK_SHIFT - 2`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all start outputs, `op_mask`, `seq_err` and `clk_err` are 0, and the decoder waits for a first-cycle write.
- R2: A write to an odd address, or to an address outside the user ROM region, is ignored in every state. It causes no start, raises no flag and does not change the sequence in progress.
- R3: Program is a first write with low byte 40h, whose upper byte is ignored, followed by a second write to the same even address. One cycle after the second write, `prog_start` pulses for one cycle with `op_addr` set to that address, `op_data` set to the second write's data and `op_mask` set to the one-hot block.
- R4: Lock-bit program is 77h then D0h (low bytes), both written to the top word of a block. It pulses `lockpgm_start` with `op_addr` set to that top word and `op_mask` set to the one-hot block whose lock bit is to be cleared to 0. A first write of 77h to any other address sets `seq_err` and returns to idle.
- R5: Block erase is 20h then D0h to the same even address. It pulses `erase_start` with `op_mask` set to the one-hot block holding that address.
- R6: Erase-all-unlocked is A7h then D0h to the same even address. It pulses `erase_start` with `op_mask` equal to `lock_bits`, where a lock bit of 1 means unlocked.
- R7: Read lock status is 71h then D0h to the same even address. It pulses `lkrd_start` with `op_addr` set to that address.
- R8: If the second write's address differs from the first, or a non-program command's second low byte is not D0h, the decoder sets `seq_err`, returns to idle and starts nothing.
- R9: If `clk_stopped` is 1 at either write of any command, nothing starts, `clk_err` is set and the decoder returns to idle.
- R10: While `seq_busy` is 1, or from a start pulse until `seq_done`, first-cycle command writes are ignored.
- R11: `seq_err` and `clk_err` stay set until a first-cycle write with low byte 50h to an even user ROM address. That write clears both flags one cycle later, even while busy.
- R12: A first-cycle low byte that matches no command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write byte address |
| wr_data | input | 16 | Bus write data |
| clk_stopped | input | 1 | Main clock stopped status |
| lock_bits | input | NUM_BLK | Per-block lock state, 1 = unlocked |
| seq_busy | input | 1 | External sequencer busy |
| seq_done | input | 1 | External sequencer finished operation |
| prog_start | output | 1 | Auto-program start pulse |
| lockpgm_start | output | 1 | Lock-bit program start pulse |
| erase_start | output | 1 | Erase start pulse (block or all-unlocked) |
| lkrd_start | output | 1 | Lock status read start pulse |
| op_addr | output | ADDR_W | Latched operation address |
| op_data | output | 16 | Latched operation data |
| op_mask | output | NUM_BLK | Block mask for the operation |
| seq_err | output | 1 | Sticky sequence error |
| clk_err | output | 1 | Sticky clock-stopped refusal |

## Verification
The bench builds the decoder with a 16-bit address, four blocks of 256 bytes and the region base at 1000h. With these values every block top (10FEh, 11FEh, 12FEh, 13FEh) and both region edges lie within short hand-written addresses. A four-bit `lock_bits` pattern can also be compared directly against the erase-all mask. The default parameters give 4 KiB blocks. The smaller values exercise the same block-index and top-word arithmetic, so the bench needs no address beyond a few kilobytes.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_LOCK  = 3'd2,
    OP_ERASE = 3'd3,
    OP_ERALL = 3'd4,
    OP_LKRD  = 3'd5
  } op_kind_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WAIT = 1'b1
  } seq_state_e;

  localparam logic [7:0] CODE_PROG    = 8'h40;
  localparam logic [7:0] CODE_LOCK    = 8'h77;
  localparam logic [7:0] CODE_ERASE   = 8'h20;
  localparam logic [7:0] CODE_ERALL   = 8'hA7;
  localparam logic [7:0] CODE_LKRD    = 8'h71;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_CLR     = 8'h50;

  // Map a first-cycle low byte to an operation kind.
  function automatic op_kind_e decode_code(input logic [7:0] code);
    case (code)
      CODE_PROG:  return OP_PROG;
      CODE_LOCK:  return OP_LOCK;
      CODE_ERASE: return OP_ERASE;
      CODE_ERALL: return OP_ERALL;
      CODE_LKRD:  return OP_LKRD;
      default:    return OP_NONE;
    endcase
  endfunction

  // Block number holding byte address a.
  function automatic logic [31:0] blk_index(input logic [31:0] a,
                                            input logic [31:0] base,
                                            input int unsigned shift);
    return (a - base) >> shift;
  endfunction

  // Address of the top word of block idx.
  function automatic logic [31:0] blk_top(input logic [31:0] base,
                                          input int unsigned shift,
                                          input logic [31:0] idx);
    return base + ((idx + 32'd1) << shift) - 32'd2;
  endfunction

endpackage

// File: rtl/fcd_addr_decode.sv
module fcd_addr_decode #(
  parameter int unsigned ADDR_W    = 20,
  parameter logic [31:0] ROM_BASE  = 32'h000F_0000,
  parameter int unsigned BLK_SHIFT = 12,
  parameter int unsigned NUM_BLK   = 8,
  localparam int unsigned BLK_W    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_rom,
  output logic              even,
  output logic [BLK_W-1:0]  blk,
  output logic              at_top
);

  localparam logic [31:0] ROM_END = ROM_BASE + (32'(NUM_BLK) << BLK_SHIFT);

  logic [31:0] a32;

  assign a32    = 32'(addr);
  assign even   = ~addr[0];
  assign in_rom = (a32 >= ROM_BASE) && (a32 < ROM_END);
  assign blk    = BLK_W'(fcd_pkg::blk_index(a32, ROM_BASE, BLK_SHIFT));
  assign at_top = in_rom &&
                  (a32 == fcd_pkg::blk_top(ROM_BASE, BLK_SHIFT, 32'(blk)));

endmodule

// File: rtl/fcd_status.sv
module fcd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_seq,
  input  logic set_clk,
  input  logic clr,
  output logic seq_err,
  output logic clk_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_err <= 1'b0;
      clk_err <= 1'b0;
    end else if (clr) begin
      seq_err <= 1'b0;
      clk_err <= 1'b0;
    end else begin
      if (set_seq) seq_err <= 1'b1;
      if (set_clk) clk_err <= 1'b1;
    end
  end

  // R11: flags hold until the clear command
  p_seq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !clr) |=> seq_err);
  p_clk_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_err && !clr) |=> clk_err);
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!seq_err && !clk_err));

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned NUM_BLK = 8,
  localparam int unsigned BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [15:0]        wr_data,
  input  logic               in_rom,
  input  logic               even,
  input  logic [BLK_W-1:0]   blk,
  input  logic               at_top,
  input  logic               clk_stopped,
  input  logic               seq_busy,
  input  logic               seq_done,
  input  logic [NUM_BLK-1:0] lock_bits,
  output op_kind_e           start_kind,
  output logic [ADDR_W-1:0]  op_addr,
  output logic [15:0]        op_data,
  output logic [NUM_BLK-1:0] op_mask,
  output logic               set_seq,
  output logic               set_clk,
  output logic               clr_req
);

  seq_state_e          state, state_nxt;
  op_kind_e            kind1;
  logic [ADDR_W-1:0]   addr1;
  logic [BLK_W-1:0]    blk1;
  logic                inflight;

  // Named internal events, used by the assertions below.
  logic                accept;
  logic                blocked;
  logic                fire;
  op_kind_e            first_kind;
  logic                open_seq;

  assign accept     = wr_en && in_rom && even;
  assign blocked    = seq_busy || inflight;
  assign first_kind = decode_code(wr_data[7:0]);

  always_comb begin
    state_nxt = state;
    set_seq   = 1'b0;
    set_clk   = 1'b0;
    clr_req   = 1'b0;
    fire      = 1'b0;
    open_seq  = 1'b0;
    case (state)
      S_IDLE: begin
        if (accept) begin
          if (wr_data[7:0] == CODE_CLR) begin
            clr_req = 1'b1;
          end else if (!blocked && first_kind != OP_NONE) begin
            if (clk_stopped) begin
              set_clk = 1'b1;
            end else if (first_kind == OP_LOCK && !at_top) begin
              set_seq = 1'b1;
            end else begin
              open_seq  = 1'b1;
              state_nxt = S_WAIT;
            end
          end
        end
      end
      S_WAIT: begin
        if (accept) begin
          state_nxt = S_IDLE;
          if (clk_stopped) begin
            set_clk = 1'b1;
          end else if (wr_addr != addr1) begin
            set_seq = 1'b1;
          end else if (kind1 != OP_PROG && wr_data[7:0] != CODE_CONFIRM) begin
            set_seq = 1'b1;
          end else begin
            fire = 1'b1;
          end
        end
      end
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind1      <= OP_NONE;
      addr1      <= '0;
      blk1       <= '0;
      inflight   <= 1'b0;
      start_kind <= OP_NONE;
      op_addr    <= '0;
      op_data    <= '0;
      op_mask    <= '0;
    end else begin
      state <= state_nxt;
      if (open_seq) begin
        kind1 <= first_kind;
        addr1 <= wr_addr;
        blk1  <= blk;
      end
      start_kind <= fire ? kind1 : OP_NONE;
      if (fire) begin
        op_addr <= addr1;
        op_data <= wr_data;
        op_mask <= (kind1 == OP_ERALL) ? lock_bits : (NUM_BLK'(1) << blk1);
      end
      if (fire)          inflight <= 1'b1;
      else if (seq_done) inflight <= 1'b0;
    end
  end

  // R2: odd-address writes change nothing
  p_odd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !even) |=> ($stable(state) && start_kind == OP_NONE));

  // R3: a start is a single-cycle pulse
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_kind != OP_NONE) |=> (start_kind == OP_NONE));

  // R8: a start follows a write to the latched address
  p_start_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_kind != OP_NONE) |-> ($past(wr_en) && $past(wr_addr) == op_addr));

  // R9: nothing starts while the main clock is stopped
  p_no_start_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_kind != OP_NONE) |-> !$past(clk_stopped));

  // R10: no sequence opens while an operation is in flight
  p_busy_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && blocked) |=> (state == S_IDLE));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int unsigned ADDR_W    = 20,
  parameter logic [31:0] ROM_BASE  = 32'h000F_0000,
  parameter int unsigned BLK_SHIFT = 12,
  parameter int unsigned NUM_BLK   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [15:0]        wr_data,
  input  logic               clk_stopped,
  input  logic [NUM_BLK-1:0] lock_bits,
  input  logic               seq_busy,
  input  logic               seq_done,
  output logic               prog_start,
  output logic               lockpgm_start,
  output logic               erase_start,
  output logic               lkrd_start,
  output logic [ADDR_W-1:0]  op_addr,
  output logic [15:0]        op_data,
  output logic [NUM_BLK-1:0] op_mask,
  output logic               seq_err,
  output logic               clk_err
);
  import fcd_pkg::*;

  localparam int unsigned BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

  logic             in_rom;
  logic             even;
  logic [BLK_W-1:0] blk;
  logic             at_top;
  op_kind_e         start_kind;
  logic             set_seq;
  logic             set_clk;
  logic             clr_req;

  fcd_addr_decode #(
    .ADDR_W   (ADDR_W),
    .ROM_BASE (ROM_BASE),
    .BLK_SHIFT(BLK_SHIFT),
    .NUM_BLK  (NUM_BLK)
  ) addr_i (
    .addr  (wr_addr),
    .in_rom(in_rom),
    .even  (even),
    .blk   (blk),
    .at_top(at_top)
  );

  fcd_seq_fsm #(
    .ADDR_W (ADDR_W),
    .NUM_BLK(NUM_BLK)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .in_rom     (in_rom),
    .even       (even),
    .blk        (blk),
    .at_top     (at_top),
    .clk_stopped(clk_stopped),
    .seq_busy   (seq_busy),
    .seq_done   (seq_done),
    .lock_bits  (lock_bits),
    .start_kind (start_kind),
    .op_addr    (op_addr),
    .op_data    (op_data),
    .op_mask    (op_mask),
    .set_seq    (set_seq),
    .set_clk    (set_clk),
    .clr_req    (clr_req)
  );

  fcd_status status_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_seq(set_seq),
    .set_clk(set_clk),
    .clr    (clr_req),
    .seq_err(seq_err),
    .clk_err(clk_err)
  );

  assign prog_start    = (start_kind == OP_PROG);
  assign lockpgm_start = (start_kind == OP_LOCK);
  assign erase_start   = (start_kind == OP_ERASE) || (start_kind == OP_ERALL);
  assign lkrd_start    = (start_kind == OP_LKRD);

  // R4: a lock-bit start always names a block top word
  p_lock_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lockpgm_start |-> (op_addr[BLK_SHIFT-1:1] == '1));

  // R5: erase starts carry a non-empty mask unless erase-all saw no unlocked block
  p_erase_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && $past(wr_data[7:0] == CODE_CONFIRM) && $past(lock_bits) != '0)
      |-> (op_mask != '0));

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/100ps
module flash_cmd_decoder_tb_top;

  localparam int unsigned ADDR_W    = 16;
  localparam logic [31:0] ROM_BASE  = 32'h0000_1000;
  localparam int unsigned BLK_SHIFT = 8;
  localparam int unsigned NUM_BLK   = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [ADDR_W-1:0]  wr_addr = '0;
  logic [15:0]        wr_data = '0;
  logic               clk_stopped = 1'b0;
  logic [NUM_BLK-1:0] lock_bits = '0;
  logic               seq_busy = 1'b0;
  logic               seq_done = 1'b0;
  logic               prog_start, lockpgm_start, erase_start, lkrd_start;
  logic [ADDR_W-1:0]  op_addr;
  logic [15:0]        op_data;
  logic [NUM_BLK-1:0] op_mask;
  logic               seq_err, clk_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .BLK_SHIFT(BLK_SHIFT), .NUM_BLK(NUM_BLK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_stopped(clk_stopped), .lock_bits(lock_bits), .seq_busy(seq_busy),
    .seq_done(seq_done), .prog_start(prog_start), .lockpgm_start(lockpgm_start),
    .erase_start(erase_start), .lkrd_start(lkrd_start), .op_addr(op_addr),
    .op_data(op_data), .op_mask(op_mask), .seq_err(seq_err), .clk_err(clk_err)
  );

  function automatic logic [15:0] top_of(input int k);
    return 16'(ROM_BASE + (k + 1) * (1 << BLK_SHIFT) - 2);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus write; returns at the falling edge after the capturing rising edge.
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); seq_done = 1'b1;
    @(negedge clk); seq_done = 1'b0;
  endtask

  function automatic logic [3:0] starts();
    return {prog_start, lockpgm_start, erase_start, lkrd_start};
  endfunction

  task automatic clear_flags();
    wr(16'h1000, 16'h0050);
    chk("R11 clear flags", {seq_err, clk_err}, 2'b00);
  endtask

  task automatic t_reset();
    chk("R1 starts at reset", starts(), 4'b0000);
    chk("R1 mask at reset", op_mask, 4'b0000);
    chk("R1 flags at reset", {seq_err, clk_err}, 2'b00);
  endtask

  task automatic t_program();
    wr(16'h1010, 16'hAB40);
    wr(16'h1010, 16'h1234);
    chk("R3 prog_start", starts(), 4'b1000);
    chk("R3 op_addr", op_addr, 16'h1010);
    chk("R3 op_data", op_data, 16'h1234);
    chk("R3 op_mask", op_mask, 4'b0001);
    @(negedge clk);
    chk("R3 single pulse", starts(), 4'b0000);
    done_pulse();
  endtask

  task automatic t_ignored_addr();
    wr(16'h1011, 16'h0040);
    chk("R2 odd first write no start", starts(), 4'b0000);
    wr(16'h0FFE, 16'h0040);
    chk("R2 out-of-region no flag", {seq_err, clk_err}, 2'b00);
    wr(16'h1020, 16'h0040);
    wr(16'h1023, 16'h9999);
    chk("R2 odd second write ignored", {starts(), seq_err}, 5'b00000);
    wr(16'h1400, 16'h8888);
    chk("R2 above region ignored", {starts(), seq_err}, 5'b00000);
    wr(16'h1020, 16'h5555);
    chk("R2 sequence survives", starts(), 4'b1000);
    chk("R2 data after ignored writes", op_data, 16'h5555);
    done_pulse();
  endtask

  task automatic t_lock();
    wr(top_of(1), 16'h0077);
    wr(top_of(1), 16'h00D0);
    chk("R4 lockpgm_start", starts(), 4'b0100);
    chk("R4 op_addr top", op_addr, 32'(top_of(1)));
    chk("R4 op_mask", op_mask, 4'b0010);
    done_pulse();
    wr(16'h11FC, 16'h0077);
    chk("R4 non-top address error", {starts(), seq_err}, 5'b00001);
    wr(16'h11FC, 16'h00D0);
    chk("R4 no start after reject", starts(), 4'b0000);
    clear_flags();
  endtask

  task automatic t_erase();
    wr(16'h1230, 16'h0020);
    wr(16'h1230, 16'h00D0);
    chk("R5 erase_start", starts(), 4'b0010);
    chk("R5 block mask", op_mask, 4'b0100);
    done_pulse();
    lock_bits = 4'b1010;
    wr(16'h1000, 16'h00A7);
    wr(16'h1000, 16'h00D0);
    chk("R6 erase-all start", starts(), 4'b0010);
    chk("R6 unlocked mask", op_mask, 4'b1010);
    done_pulse();
    lock_bits = 4'b0000;
  endtask

  task automatic t_lkrd();
    wr(top_of(3), 16'h0071);
    wr(top_of(3), 16'h00D0);
    chk("R7 lkrd_start", starts(), 4'b0001);
    chk("R7 op_addr", op_addr, 32'(top_of(3)));
    done_pulse();
  endtask

  task automatic t_seq_err();
    wr(16'h1010, 16'h0040);
    wr(16'h1012, 16'h1111);
    chk("R8 address mismatch", {starts(), seq_err}, 5'b00001);
    wr(16'h1020, 16'h0020);
    wr(16'h1020, 16'h00C0);
    chk("R8 bad confirm", {starts(), seq_err}, 5'b00001);
    wr(16'h1020, 16'h00D0);
    chk("R8 back to idle", starts(), 4'b0000);
    repeat (3) @(negedge clk);
    chk("R11 seq_err sticky", seq_err, 1'b1);
    clear_flags();
  endtask

  task automatic t_clk_stop();
    clk_stopped = 1'b1;
    wr(16'h1010, 16'h0040);
    chk("R9 refused at first write", {starts(), clk_err, seq_err}, 6'b000010);
    wr(16'h1010, 16'h1234);
    chk("R9 idle after refusal", starts(), 4'b0000);
    clk_stopped = 1'b0;
    clear_flags();
    wr(16'h1100, 16'h0020);
    clk_stopped = 1'b1;
    wr(16'h1100, 16'h00D0);
    chk("R9 refused at second write", {starts(), clk_err}, 5'b00001);
    clk_stopped = 1'b0;
    wr(16'h1100, 16'h00D0);
    chk("R9 no late start", starts(), 4'b0000);
    clear_flags();
  endtask

  task automatic t_busy();
    seq_busy = 1'b1;
    wr(16'h1010, 16'h0040);
    wr(16'h1010, 16'h0020);
    chk("R10 busy ignores commands", {starts(), seq_err}, 5'b00000);
    wr(16'h1000, 16'h0040);
    wr(16'h1000, 16'h00D0);
    chk("R10 busy still ignores", {starts(), seq_err}, 5'b00000);
    seq_busy = 1'b0;
    wr(16'h1040, 16'h0040);
    wr(16'h1040, 16'h7777);
    chk("R10 program after busy", starts(), 4'b1000);
    wr(16'h1050, 16'h0040);
    wr(16'h1050, 16'h6666);
    chk("R10 in-flight ignores", {starts(), seq_err}, 5'b00000);
    chk("R10 data kept", op_data, 16'h7777);
    done_pulse();
    wr(16'h1050, 16'h0040);
    wr(16'h1050, 16'h6666);
    chk("R10 accepted after done", starts(), 4'b1000);
    done_pulse();
    wr(16'h1010, 16'h0040);
    wr(16'h1012, 16'h0000);
    seq_busy = 1'b1;
    wr(16'h1010, 16'h0050);
    chk("R11 clear while busy", seq_err, 1'b0);
    seq_busy = 1'b0;
  endtask

  task automatic t_unknown();
    wr(16'h1010, 16'h00FF);
    wr(16'h1010, 16'h00D0);
    chk("R12 unknown code ignored", {starts(), seq_err, clk_err}, 6'b000000);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_ignored_addr();
    t_lock();
    t_erase();
    t_lkrd();
    t_seq_err();
    t_clk_stop();
    t_busy();
    t_unknown();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule